// File: doc/BRIEF.md
# Serpent Round-Key Expansion Unit

This block expands a user key into the 33 round keys that a Serpent cipher datapath needs. It accepts a key of 128, 192 or 256 bits with a two-bit length code. A short key is padded to 256 bits. The padded key seeds a window of eight 32-bit prekey words. The unit then computes one new prekey per clock through the golden-ratio affine recurrence, rotated left by 11.

Every four prekeys form one round key. The unit passes them through an S-box in bitsliced form and then through the initial bit permutation. Each round key leaves on a 128-bit bus with its index and a one-cycle valid strobe, so that the datapath can write it into its own key bank.

The keys come out in ascending order, K0 first and K32 last. A one-cycle done pulse follows K32. A consumer that decrypts can take that pulse as the point from which it may read its stored bank in reverse. A start request is only taken while the unit is idle.

Top module: `serpent_keyexp`

## Requirements
- R1: A key shorter than 256 bits is padded by setting the bit just above its most significant bit to 1 and every higher bit to 0. Input key bits at or above the selected length have no effect on any round key.
- R2: The length code selects the key size: 2'b00 is 128 bits, 2'b01 is 192 bits, and 2'b10 or 2'b11 is 256 bits.
- R3: The starting prekeys w-8 through w-1 are taken from the padded key, with w-8 = key[31:0] and w-1 = key[255:224]. Each later prekey is wi = rotl32(w(i-1) ^ w(i-3) ^ w(i-5) ^ w(i-8) ^ 32'h9E3779B9 ^ i, 11), for i = 0 to 131.
- R4: Round key Kg is built from w4g, w4g+1, w4g+2 and w4g+3. For each k from 0 to 31, the nibble {w4g+3[k], w4g+2[k], w4g+1[k], w4g[k]} goes through S-box number (3 - g) mod 8, and the result forms bits [4k+3:4k] of Kg.
- R5: Keys K0 to K32 are presented in order, with the index on `rk_index`. Kg is valid for exactly one cycle, beginning after the (4g+5)th rising edge that follows the edge which accepted the start.
- R6: `done` pulses for one cycle, on the cycle right after K32 is valid. `busy` falls on the same edge.
- R7: A start request while `busy` is high is ignored. The key sequence already running completes unchanged.
- R8: After reset, `rk_valid`, `done` and `busy` are low.
- R9: `busy` rises on the edge that accepts a start and stays high until `done` is raised. `rk_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to expand the key presented with it |
| key_len | input | 2 | Key length code (see R2) |
| key_in | input | 256 | User key, LSB-aligned |
| busy | output | 1 | Expansion in progress |
| rk_valid | output | 1 | Round key strobe |
| rk_index | output | 6 | Index of the key on `rk_data` |
| rk_data | output | 128 | Round key |
| done | output | 1 | One-cycle pulse after the last key |

## Verification
All results are due at a fixed number of edges after the edge that accepted the start, so the bench counts edges from that point. It expects key g after edge 4g+5, `done` and the fall of `busy` after edge 134, and no strobe at any other edge. Each sample is taken one nanosecond after the edge, once every register has settled. A start request injected in the middle of a run must leave that count unchanged and every key equal to the model of the first request.

// File: rtl/serpent_ks_pkg.sv
package serpent_ks_pkg;

    localparam int WORD_W   = 32;
    localparam int WIN_N    = 8;
    localparam int KEY_W    = WORD_W * WIN_N;
    localparam int BLK_W    = 128;
    localparam int NIB_N    = BLK_W / 4;
    localparam int NUM_RK   = 33;
    localparam int NUM_PRE  = NUM_RK * 4;
    localparam int ROT_L    = 11;
    localparam int IDX_W    = $clog2(NUM_PRE);
    localparam int RKI_W    = $clog2(NUM_RK);
    localparam logic [WORD_W-1:0] PHI = 32'h9E3779B9;

    // nibble x of entry s is bits [4x+3:4x]
    localparam logic [63:0] SBOX_TBL [8] = '{
        64'hC90724DE_B56A1F83,
        64'h43D68EB1_A50972CF,
        64'h25B04E1D_FAC39768,
        64'hE57A421D_369C8BF0,
        64'hD7E9A452_6B0C38F1,
        64'h176D8E30_C9A4B25F,
        64'h0A3DF19E_B6485C27,
        64'h6539AC47_B28E0FD1
    };

    function automatic logic [3:0] sbox_nib(input logic [2:0] sel, input logic [3:0] x);
        logic [63:0] t;
        t = SBOX_TBL[sel];
        return t[{x, 2'b00} +: 4];
    endfunction

endpackage

// File: rtl/serpent_ks_pad.sv
module serpent_ks_pad
    import serpent_ks_pkg::*;
(
    input  logic [1:0]       len_code,
    input  logic [KEY_W-1:0] key_raw,
    output logic [KEY_W-1:0] key_full
);
    int unsigned nbits;

    always_comb begin
        case (len_code)
            2'b00:   nbits = 128;
            2'b01:   nbits = 192;
            default: nbits = KEY_W;
        endcase
        for (int b = 0; b < KEY_W; b++) begin
            if (b < nbits) key_full[b] = key_raw[b];
            else           key_full[b] = (b == nbits);
        end
    end
endmodule

// File: rtl/serpent_ks_step.sv
module serpent_ks_step
    import serpent_ks_pkg::*;
(
    input  logic [WORD_W-1:0] w_m1,
    input  logic [WORD_W-1:0] w_m3,
    input  logic [WORD_W-1:0] w_m5,
    input  logic [WORD_W-1:0] w_m8,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] w_new
);
    logic [WORD_W-1:0] mix;

    always_comb begin
        mix   = w_m1 ^ w_m3 ^ w_m5 ^ w_m8 ^ PHI ^ {{(WORD_W-IDX_W){1'b0}}, idx};
        w_new = {mix[WORD_W-ROT_L-1:0], mix[WORD_W-1:WORD_W-ROT_L]};
    end
endmodule

// File: rtl/serpent_ks_rkey.sv
module serpent_ks_rkey
    import serpent_ks_pkg::*;
(
    input  logic [3:0][WORD_W-1:0] grp,
    input  logic [2:0]             sel,
    output logic [BLK_W-1:0]       rkey
);
    logic [3:0][WORD_W-1:0] slc;

    for (genvar k = 0; k < WORD_W; k++) begin : g_slice
        logic [3:0] y;
        assign y = sbox_nib(sel, {grp[3][k], grp[2][k], grp[1][k], grp[0][k]});
        assign slc[0][k] = y[0];
        assign slc[1][k] = y[1];
        assign slc[2][k] = y[2];
        assign slc[3][k] = y[3];
    end

    // initial permutation: out bit 4k+m takes in bit 32m+k
    for (genvar k = 0; k < NIB_N; k++) begin : g_ip_k
        for (genvar m = 0; m < 4; m++) begin : g_ip_m
            assign rkey[4*k+m] = slc[m][k];
        end
    end
endmodule

// File: rtl/serpent_keyexp.sv
module serpent_keyexp
    import serpent_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       key_len,
    input  logic [KEY_W-1:0] key_in,
    output logic             busy,
    output logic             rk_valid,
    output logic [RKI_W-1:0] rk_index,
    output logic [BLK_W-1:0] rk_data,
    output logic             done
);
    typedef struct packed {
        logic                        busy;
        logic                        run;
        logic [IDX_W-1:0]            idx;
        logic                        pend;
        logic [2:0]                  sel;
        logic [RKI_W-1:0]            kidx;
        logic [WIN_N-1:0][WORD_W-1:0] win;
        logic                        valid;
        logic [RKI_W-1:0]            out_idx;
        logic [BLK_W-1:0]            rk;
        logic                        done;
    } ks_state_t;

    ks_state_t st_q, st_d;

    logic [KEY_W-1:0]  key_full;
    logic [WORD_W-1:0] w_new;
    logic [BLK_W-1:0]  rk_comb;

    serpent_ks_pad u_pad (
        .len_code (key_len),
        .key_raw  (key_in),
        .key_full (key_full)
    );

    serpent_ks_step u_step (
        .w_m1  (st_q.win[7]),
        .w_m3  (st_q.win[5]),
        .w_m5  (st_q.win[3]),
        .w_m8  (st_q.win[0]),
        .idx   (st_q.idx),
        .w_new (w_new)
    );

    serpent_ks_rkey u_rkey (
        .grp  (st_q.win[7:4]),
        .sel  (st_q.sel),
        .rkey (rk_comb)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.done  = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.run  = 1'b1;
                st_d.idx  = '0;
                st_d.pend = 1'b0;
                st_d.sel  = 3'd3;
                st_d.kidx = '0;
                st_d.win  = key_full;
            end
        end else begin
            st_d.pend = 1'b0;
            if (st_q.run) begin
                st_d.win  = {w_new, st_q.win[WIN_N-1:1]};
                st_d.idx  = st_q.idx + 1'b1;
                st_d.pend = (st_q.idx[1:0] == 2'b11);
                if (st_q.idx == IDX_W'(NUM_PRE - 1)) st_d.run = 1'b0;
            end
            if (st_q.pend) begin
                st_d.valid   = 1'b1;
                st_d.rk      = rk_comb;
                st_d.out_idx = st_q.kidx;
                st_d.kidx    = st_q.kidx + 1'b1;
                st_d.sel     = st_q.sel - 1'b1;
            end
            if (st_q.valid && st_q.out_idx == RKI_W'(NUM_RK - 1)) begin
                st_d.done = 1'b1;
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign rk_valid = st_q.valid;
    assign rk_index = st_q.out_idx;
    assign rk_data  = st_q.rk;
    assign done     = st_q.done;

    // R3: prekey counter never passes the last prekey
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> st_q.idx <= IDX_W'(NUM_PRE - 1));

    // R5: consecutive keys are four cycles apart with increasing index
    a_r5_key_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_valid && rk_index != '0) |->
            ($past(rk_valid, 4) && $past(rk_index, 4) == rk_index - 1'b1));

    // R6: done comes only right after the last key
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rk_valid) && $past(rk_index) == RKI_W'(NUM_RK - 1) && !busy));

    // R7: an active run ignores a new request
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && st_q.run) |=> busy);

    // R9: no key strobe while idle, never together with done
    a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rk_valid |-> (busy && !done));
endmodule

// File: tb/serpent_keyexp_test.sv
module serpent_keyexp_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   key_len = 2'b00;
    logic [255:0] key_in = '0;
    logic         busy, rk_valid, done;
    logic [5:0]   rk_index;
    logic [127:0] rk_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [127:0] exp_rk [33];
    int sb [8][16] = '{
        '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12},
        '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4},
        '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2},
        '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14},
        '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13},
        '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1},
        '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0},
        '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6}
    };

    always #2.5 clk = ~clk;

    serpent_keyexp uut (
        .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .key_in(key_in),
        .busy(busy), .rk_valid(rk_valid), .rk_index(rk_index), .rk_data(rk_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // model of padding, recurrence and S-box/permutation (R1-style tags written below)
    task automatic model(input logic [255:0] k, input logic [1:0] len);
        logic [255:0] kf;
        logic [31:0]  w [140];
        int nb;
        nb = (len == 2'b00) ? 128 : (len == 2'b01) ? 192 : 256;   // R2
        for (int b = 0; b < 256; b++) kf[b] = (b < nb) ? k[b] : (b == nb);  // R1
        for (int j = 0; j < 8; j++) w[j] = kf[32*j +: 32];                   // R3
        for (int i = 0; i < 132; i++) begin
            logic [31:0] t;
            t = w[i+7] ^ w[i+5] ^ w[i+3] ^ w[i] ^ 32'h9E3779B9 ^ 32'(i);
            w[i+8] = {t[20:0], t[31:21]};
        end
        for (int g = 0; g < 33; g++) begin                                   // R4
            int s;
            s = (35 - g) % 8;
            for (int b = 0; b < 32; b++) begin
                int n;
                n = {w[8+4*g+3][b], w[8+4*g+2][b], w[8+4*g+1][b], w[8+4*g][b]};
                exp_rk[g][4*b +: 4] = 4'(sb[s][n]);
            end
        end
    endtask

    task automatic run_key(input logic [255:0] k, input logic [1:0] len, input bit poke, input string tag);
        model(k, len);
        @(negedge clk);
        key_in = k; key_len = len; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        key_in = ~k;   // R1/R7: later key input must not matter
        for (int c = 1; c <= 135; c++) begin
            if (poke && c == 50) begin
                @(negedge clk);
                start = 1'b1; key_len = 2'b10;
            end
            @(posedge clk);
            #1;
            if (poke && c == 50) start = 1'b0;
            if (c % 4 == 1 && c >= 5 && c <= 133) begin
                int g;
                g = (c - 5) / 4;
                check(rk_valid === 1'b1 && rk_index === 6'(g), "R5 key strobe/index",
                      {121'b0, rk_valid, rk_index}, {121'b0, 1'b1, 6'(g)});
                check(rk_data === exp_rk[g], {tag, " R4 round key"}, rk_data, exp_rk[g]);
            end else if (c < 134) begin
                if (rk_valid !== 1'b0)
                    check(1'b0, "R5 stray strobe", {127'b0, rk_valid}, 128'd0);
            end
            if (c == 133) check(busy === 1'b1 && done === 1'b0, "R9 busy through last key",
                                {126'b0, busy, done}, 128'd2);
            if (c == 134) check(done === 1'b1 && busy === 1'b0 && rk_valid === 1'b0,
                                "R6 done pulse", {125'b0, done, busy, rk_valid}, 128'd4);
            if (c == 135) check(done === 1'b0 && busy === 1'b0, "R6 done single cycle",
                                {126'b0, done, busy}, 128'd0);
        end
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int j = 0; j < 8; j++) r[32*j +: 32] = $urandom();
        return r;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check(rk_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "R8 reset state",
              {125'b0, rk_valid, done, busy}, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // idle: start low keeps outputs quiet (R9)
        repeat (4) @(posedge clk);
        #1;
        check(busy === 1'b0 && rk_valid === 1'b0, "R9 idle", {126'b0, busy, rk_valid}, 128'd0);

        run_key('0, 2'b00, 1'b0, "zero key 128");
        run_key({256{1'b1}}, 2'b00, 1'b0, "R1 high bits set 128");
        run_key({256{1'b1}}, 2'b01, 1'b0, "R1 high bits set 192");
        run_key(rnd256(), 2'b10, 1'b0, "R2 256");
        run_key(rnd256(), 2'b11, 1'b0, "R2 code 3");
        run_key(rnd256(), 2'b01, 1'b1, "R7 start while busy");
        for (int r = 0; r < 4; r++) begin
            logic [1:0] l;
            l = 2'($urandom_range(0, 3));
            run_key(rnd256(), l, 1'b0, "random R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule